// File: doc/BRIEF.md
# Target Clock and Reset Sequencer

This block powers an attached 8-bit microprocessor up and down in a safe order. From the system clock it derives a square target clock whose period, in system clocks, is taken from a host register when a start command arrives. It also drives the target's active-low reset. A start pulse sets the target clock running and keeps reset asserted until the clock has completed three full cycles. Only then is reset released and the running flag raised.

A stop pulse reverses the order. Reset is asserted on the same system clock edge, and the target clock finishes its current period and then parks low. The target is therefore never left with reset released and no clock.

After power-on the target sits in reset with its clock stopped until the host issues the first start. Commands that make no sense in the current state are dropped: a start while the sequence is active, or a stop while it is idle.

Top module: `tgt_clkrst_seq`

## Requirements
- R1: After the synchronous reset `rst`, `tgt_clk_o` is 0, `tgt_rst_n_o` is 0 and `running_o` is 0, and they stay that way until a start is accepted.
- R2: A start accepted on edge k drives `tgt_clk_o` high after edge k. `tgt_rst_n_o` goes to 1 after edge k+3P, where P is the effective period, once three full target clock cycles have completed. `tgt_clk_o` is low in the cycle just before that release.
- R3: With effective period P, each target clock cycle is high for floor(P/2) system clocks and then low for P-floor(P/2), giving a 50% duty cycle for even P. After edge k+j of an active sequence, `tgt_clk_o` equals ((j mod P) < floor(P/2)).
- R4: A stop accepted on edge m while reset is released drives `tgt_rst_n_o` to 0 after edge m. The target clock completes its current period and then stays 0, so reset is always asserted before the clock stops.
- R5: A `period_i` value below 2 is treated as a period of 2.
- R6: `period_i` is sampled only on the edge that accepts a start, so later changes have no effect on the running clock.
- R7: A start while warming up, running or halting is ignored. A stop while idle is ignored. When start and stop arrive together, the start is taken if idle and the stop is taken otherwise.
- R8: `running_o` is 1 exactly while `tgt_rst_n_o` is 1.
- R9: A stop during the warm-up phase keeps reset asserted throughout. The clock halts at the end of its current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle start command |
| stop_i | input | 1 | Single-cycle stop command |
| period_i | input | PER_W | Target clock period in system clocks, sampled at start |
| tgt_clk_o | output | 1 | Generated target clock |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| running_o | output | 1 | High while the target is out of reset |

## Verification
A cycle-level reference model in the bench predicts all three outputs on every cycle. It is driven first by directed cases and then by random periods from 0 to 15 with randomly placed start and stop pulses. Period values of 1, 4 and 7 separate the clamp, the even-duty split and the odd-period floor split. A stop in warm-up, a stop in run, a stop aligned with the end of a period, and repeated or simultaneous commands separate correct release and halt ordering from off-by-one-period errors and from commands that are wrongly accepted. A change of `period_i` in mid-run shows whether the period is resampled when it should not be.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2,
    ST_HALT = 2'd3
  } seq_st_t;
endpackage

// File: rtl/tgt_clk_gen.sv
module tgt_clk_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             hold_i,
  output logic             tclk_o,
  output logic             active_o,
  output logic             wrap_o
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  logic [PER_W-1:0] per_q, ph_q, ph_n, hi_len, per_eff;
  logic             tclk_q, act_q;

  assign per_eff = (per_i < MIN_PER) ? MIN_PER : per_i;
  assign hi_len  = per_q >> 1;
  assign wrap_o  = act_q && (ph_q == per_q - PER_W'(1));
  assign ph_n    = wrap_o ? '0 : ph_q + PER_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= MIN_PER;
      ph_q   <= '0;
      tclk_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      per_q  <= per_eff;
      ph_q   <= '0;
      tclk_q <= 1'b1;
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (wrap_o && hold_i) begin
        act_q  <= 1'b0;
        tclk_q <= 1'b0;
        ph_q   <= '0;
      end else begin
        ph_q   <= ph_n;
        tclk_q <= (ph_n < hi_len);
      end
    end
  end

  assign tclk_o   = tclk_q;
  assign active_o = act_q;

  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (per_q >= MIN_PER)); // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !tclk_q); // R4
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
    (act_q && $past(act_q) && !$past(load_i)) |-> $stable(per_q)); // R6
endmodule

// File: rtl/tgt_seq_fsm.sv
module tgt_seq_fsm
  import tgt_seq_pkg::*;
#(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  input  logic wrap_i,
  output logic load_o,
  output logic hold_o,
  output logic trst_n_o,
  output logic running_o
);
  localparam int CYC_W = $clog2(MIN_CYC + 1);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(MIN_CYC - 1);

  seq_st_t          st_q;
  logic [CYC_W-1:0] cyc_q;
  logic             trst_n_q, run_q;

  assign load_o = (st_q == ST_OFF) && start_i;
  assign hold_o = (st_q == ST_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      cyc_q    <= '0;
      trst_n_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_OFF: if (start_i) begin
          st_q  <= ST_WARM;
          cyc_q <= '0;
        end
        ST_WARM: begin
          if (stop_i) begin
            st_q <= ST_HALT;
          end else if (wrap_i) begin
            if (cyc_q == LAST_CYC) begin
              st_q     <= ST_RUN;
              trst_n_q <= 1'b1;
              run_q    <= 1'b1;
            end else begin
              cyc_q <= cyc_q + CYC_W'(1);
            end
          end
        end
        ST_RUN: if (stop_i) begin
          st_q     <= ST_HALT;
          trst_n_q <= 1'b0;
          run_q    <= 1'b0;
        end
        default: if (wrap_i) st_q <= ST_OFF;
      endcase
    end
  end

  assign trst_n_o  = trst_n_q;
  assign running_o = run_q;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && start_i && !stop_i) |=> (st_q == ST_RUN && trst_n_q)); // R7
  AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF && stop_i && !start_i) |=> (st_q == ST_OFF && !trst_n_q)); // R7
  AST_WARM_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WARM && stop_i) |=> !trst_n_q); // R9
endmodule

// File: rtl/tgt_clkrst_seq.sv
module tgt_clkrst_seq #(
  parameter int PER_W   = 8,
  parameter int MIN_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tgt_clk_o,
  output logic             tgt_rst_n_o,
  output logic             running_o
);
  logic load, hold, wrap, clk_active;

  tgt_seq_fsm #(.MIN_CYC(MIN_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wrap_i    (wrap),
    .load_o    (load),
    .hold_o    (hold),
    .trst_n_o  (tgt_rst_n_o),
    .running_o (running_o)
  );

  tgt_clk_gen #(.PER_W(PER_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .per_i    (period_i),
    .hold_i   (hold),
    .tclk_o   (tgt_clk_o),
    .active_o (clk_active),
    .wrap_o   (wrap)
  );

  AST_RELEASE_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_rst_n_o) |-> (!$past(tgt_clk_o) && clk_active)); // R2
  AST_RESET_BEFORE_HALT: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_active) |-> (!tgt_rst_n_o && !$past(tgt_rst_n_o))); // R4
  AST_RESET_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_n_o |-> clk_active); // R4
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    running_o == tgt_rst_n_o); // R8
endmodule

// File: tb/test_tgt_clkrst_seq.sv
module test_tgt_clkrst_seq;
  localparam int PER_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [PER_W-1:0] period_i = '0;
  logic             tgt_clk_o, tgt_rst_n_o, running_o;

  int nchk = 0;
  int nfail = 0;
  string cur_tag = "R3";
  bit done = 0;

  // model state: 0 idle, 1 warm-up, 2 run, 3 halting
  int mst = 0, mP = 2, mj = 0, mcyc = 0;

  always #5 clk = ~clk;

  tgt_clkrst_seq #(.PER_W(PER_W), .MIN_CYC(3)) i_tgt_clkrst_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .period_i(period_i), .tgt_clk_o(tgt_clk_o),
    .tgt_rst_n_o(tgt_rst_n_o), .running_o(running_o)
  );

  function automatic int eff_period(int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic bit exp_clk(int st, int j, int p);
    if (st == 0) return 1'b0;
    return ((j % p) < (p / 2));
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mst = 0; mj = 0; mcyc = 0;
    end else begin
      case (mst)
        0: if (start_i) begin mP = eff_period(int'(period_i)); mj = 0; mcyc = 0; mst = 1; end
        1: begin
          mj++;
          if (stop_i) mst = 3;
          else if (mj % mP == 0) begin mcyc++; if (mcyc == 3) mst = 2; end
        end
        2: begin mj++; if (stop_i) mst = 3; end
        default: begin mj++; if (mj % mP == 0) mst = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_tag, " clock (R3)"}, int'(tgt_clk_o), int'(exp_clk(mst, mj, mP)));
      chk({cur_tag, " reset (R2)"}, int'(tgt_rst_n_o), int'(mst == 2));
      chk({cur_tag, " running (R8)"}, int'(running_o), int'(mst == 2));
    end
  end

  task automatic go(int p);
    @(negedge clk); start_i = 1'b1; period_i = PER_W'(p);
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state held while idle
    cur_tag = "R1";
    wait_n(3);
    chk("R1 clock idle", int'(tgt_clk_o), 0);
    chk("R1 reset held", int'(tgt_rst_n_o), 0);

    // R2: release exactly 3 periods after start, P=4
    cur_tag = "R2";
    go(4);
    chk("R2 clock starts high", int'(tgt_clk_o), 1);
    wait_n(11);
    chk("R2 reset still held at 3P-1", int'(tgt_rst_n_o), 0);
    wait_n(1);
    chk("R2 reset released at 3P", int'(tgt_rst_n_o), 1);

    // R6: change period while running
    cur_tag = "R6";
    @(negedge clk); period_i = PER_W'(10);
    wait_n(20);

    // R7: extra start while running is ignored
    cur_tag = "R7";
    go(6);
    wait_n(9);
    chk("R7 still running after start", int'(running_o), 1);

    // R4: stop asserts reset at once
    cur_tag = "R4";
    halt();
    chk("R4 reset asserted after stop", int'(tgt_rst_n_o), 0);
    wait_n(8);
    chk("R4 clock parked low", int'(tgt_clk_o), 0);

    // R7: stop while idle ignored
    cur_tag = "R7";
    halt();
    wait_n(3);
    chk("R7 idle after stop", int'(tgt_clk_o), 0);

    // R5: period 1 clamps to 2
    cur_tag = "R5";
    go(1);
    chk("R5 phase0 high", int'(tgt_clk_o), 1);
    wait_n(1);
    chk("R5 phase1 low", int'(tgt_clk_o), 0);
    wait_n(1);
    chk("R5 phase2 high", int'(tgt_clk_o), 1);
    wait_n(10);
    halt();
    wait_n(4);
    go(0);
    wait_n(10);
    halt();
    wait_n(4);

    // R3: odd period 7
    cur_tag = "R3";
    go(7);
    wait_n(40);
    halt();
    wait_n(10);

    // R9: stop during warm-up
    cur_tag = "R9";
    go(5);
    wait_n(6);
    halt();
    wait_n(30);
    chk("R9 never released", int'(running_o), 0);
    chk("R9 clock halted", int'(tgt_clk_o), 0);

    // R7: simultaneous start and stop while idle -> start wins
    cur_tag = "R7";
    @(negedge clk); start_i = 1'b1; stop_i = 1'b1; period_i = PER_W'(3);
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    chk("R7 start wins when idle", int'(tgt_clk_o), 1);
    wait_n(12);
    @(negedge clk); start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    chk("R7 stop wins when running", int'(tgt_rst_n_o), 0);
    wait_n(6);

    // random phase
    cur_tag = "R3";
    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      go(int'($urandom_range(0, 15)));
      wait_n(int'($urandom_range(0, 60)));
      if ($urandom_range(0, 3) == 0) go(int'($urandom_range(0, 15)));
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk); period_i = PER_W'($urandom_range(0, 15));
      end
      halt();
      wait_n(int'($urandom_range(0, 20)));
    end
    wait_n(20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule